// File: doc/BRIEF.md
# Non-Restoring Divide Step Unit

This block is the datapath of a non-restoring divider that builds its quotient one bit per clock. It keeps a double-width register pair, an upper partial-remainder word and a lower word, plus a one-bit quotient-control flag. A sequencer outside the block loads the dividend and the flag, then issues divide steps, one per cycle. Two kinds of step exist. A sign step begins a signed division. A conditional step subtracts or adds the divisor, as the flag selects. The quotient collects in the lower word as the dividend bits shift out of it.

An unsigned division clears the flag at load time and then issues `DATA_W` conditional steps. A signed division issues one sign step and then `DATA_W-1` conditional steps. The quotient has fractional alignment: with the dividend held as a double-width value N and a divisor D, the final lower word is floor(N / 2D) whenever the divisor is positive and the upper dividend word is below it.

The block applies no correction. A negative divisor in signed mode usually gives a quotient one LSB low. An unsigned divisor with its top bit set gives a meaningless quotient. Overflow detection and remainder fix-up are left to the code around the block.

Top module: `divstep_unit`

## Requirements
- R1: After reset the upper word, the lower word and the flag all read zero.
- R2: When `ld_en` is high, the next clock writes `ld_hi`, `ld_lo` and `ld_flag` into the upper word, the lower word and the flag. Load takes priority over a step requested in the same cycle.
- R3: With both `ld_en` and `step_en` low, the upper word, the lower word and the flag keep their values.
- R4: A sign step (`step_en`=1, `step_sign`=1) sets the flag to the XOR of the divisor MSB and the upper-word MSB. It then shifts the pair left by one bit. The upper word takes the old lower-word MSB as its LSB, and the lower word takes the new flag as its LSB.
- R5: A conditional step (`step_en`=1, `step_sign`=0) forms upper word minus divisor when the flag is 0, and upper word plus divisor when the flag is 1. The operation is modulo 2^DATA_W, and the carry out is dropped.
- R6: After a conditional step the new flag is the XOR of the divisor MSB and the MSB of the R5 result. The upper word becomes the result shifted left by one, with the old lower-word MSB as its LSB. The lower word shifts left by one, with the inverted new flag as its LSB.
- R7: Unsigned division: load the flag as 0, then issue DATA_W conditional steps. If 0 < D < 2^(DATA_W-1) and upper word < D, the lower word ends as floor(N / 2D).
- R8: Signed division: issue one sign step, then DATA_W-1 conditional steps. If 0 < D < 2^(DATA_W-1) and 0 <= upper word < D, the lower word ends as floor(N / 2D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load strobe for the pair and the flag |
| ld_hi | input | DATA_W | Upper dividend word to load |
| ld_lo | input | DATA_W | Lower dividend word to load |
| ld_flag | input | 1 | Flag value to load |
| step_en | input | 1 | Advance by one divide step |
| step_sign | input | 1 | 1 selects the sign step, 0 the conditional step |
| divisor | input | DATA_W | Divisor, held stable during a division |
| quot | output | DATA_W | Lower word, which ends as the quotient |
| rem_hi | output | DATA_W | Upper partial-remainder word |
| qflag | output | 1 | Quotient-control flag |

## Verification
The bench uses an 8-bit configuration and runs full divisions with every legal positive divisor. Each divisor is paired with several upper and lower dividend words, in both the unsigned and the signed sequence. Pairing every divisor with these dividend patterns makes a wrong add/subtract choice or a misplaced quotient bit show up in at least one quotient.

Single steps are checked separately. A case where the add wraps and a case where the subtract borrows separate the dropped carry from a wider sum. Sign steps with each sign combination separate the flag XOR from a plain copy of the flag. Cycles with no strobe, and cycles with load and step together, show hold behaviour and load priority.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

   // Operation chosen for the coming clock edge.
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_SIGN = 2'd2,
      OP_COND = 2'd3
   } divstep_op_e;

   // Adder build variants.
   localparam int ADDSUB_SHARED = 0;  // one adder, divisor inverted on subtract
   localparam int ADDSUB_DUAL   = 1;  // separate adder and subtractor, muxed

endpackage

// File: rtl/divstep_decode.sv
module divstep_decode
   import divstep_pkg::*;
(
   input  logic        ld_en,
   input  logic        step_en,
   input  logic        step_sign,
   output divstep_op_e op
);

   always_comb begin
      if (ld_en)
         op = OP_LOAD;
      else if (step_en && step_sign)
         op = OP_SIGN;
      else if (step_en)
         op = OP_COND;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/divstep_addsub.sv
module divstep_addsub
   import divstep_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IMPL   = ADDSUB_SHARED
) (
   input  logic [DATA_W-1:0] upper,
   input  logic [DATA_W-1:0] divisor,
   input  logic              add_sel,   // 1: add, 0: subtract
   output logic [DATA_W-1:0] result,
   output logic              flag_next
);

   localparam int MSB = DATA_W - 1;

   generate
      if (IMPL == ADDSUB_SHARED) begin : g_shared
         logic [DATA_W-1:0] operand_b;
         logic [DATA_W-1:0] carry_in;
         always_comb begin
            operand_b = add_sel ? divisor : ~divisor;
            carry_in  = {{(DATA_W-1){1'b0}}, ~add_sel};
            result    = upper + operand_b + carry_in;
         end
      end else begin : g_dual
         logic [DATA_W-1:0] sum_w;
         logic [DATA_W-1:0] dif_w;
         always_comb begin
            sum_w  = upper + divisor;
            dif_w  = upper - divisor;
            result = add_sel ? sum_w : dif_w;
         end
      end
   endgenerate

   assign flag_next = divisor[MSB] ^ result[MSB];

endmodule

// File: rtl/divstep_shift.sv
module divstep_shift #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] upper_src,
   input  logic [DATA_W-1:0] lower_src,
   input  logic              ins_bit,
   output logic [DATA_W-1:0] upper_next,
   output logic [DATA_W-1:0] lower_next
);

   localparam int MSB = DATA_W - 1;

   assign upper_next = {upper_src[MSB-1:0], lower_src[MSB]};
   assign lower_next = {lower_src[MSB-1:0], ins_bit};

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
   import divstep_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IMPL   = ADDSUB_SHARED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_hi,
   input  logic [DATA_W-1:0] ld_lo,
   input  logic              ld_flag,
   input  logic              step_en,
   input  logic              step_sign,
   input  logic [DATA_W-1:0] divisor,
   output logic [DATA_W-1:0] quot,
   output logic [DATA_W-1:0] rem_hi,
   output logic              qflag
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("divstep_unit: DATA_W must be at least 4");
      end
      if (IMPL != ADDSUB_SHARED && IMPL != ADDSUB_DUAL) begin : g_bad_impl
         $error("divstep_unit: IMPL selects no adder variant");
      end
   endgenerate

   logic [DATA_W-1:0] hi_q, lo_q;
   logic              fl_q;
   divstep_op_e       op;

   logic [DATA_W-1:0] as_result;
   logic              as_flag;
   logic              sign_flag;
   logic [DATA_W-1:0] sh_src, sh_hi, sh_lo;
   logic              sh_ins;

   divstep_decode u_dec (
      .ld_en     (ld_en),
      .step_en   (step_en),
      .step_sign (step_sign),
      .op        (op)
   );

   divstep_addsub #(.DATA_W(DATA_W), .IMPL(IMPL)) u_as (
      .upper     (hi_q),
      .divisor   (divisor),
      .add_sel   (fl_q),
      .result    (as_result),
      .flag_next (as_flag)
   );

   assign sign_flag = divisor[MSB] ^ hi_q[MSB];

   always_comb begin
      if (op == OP_SIGN) begin
         sh_src = hi_q;
         sh_ins = sign_flag;
      end else begin
         sh_src = as_result;
         sh_ins = ~as_flag;
      end
   end

   divstep_shift #(.DATA_W(DATA_W)) u_sh (
      .upper_src  (sh_src),
      .lower_src  (lo_q),
      .ins_bit    (sh_ins),
      .upper_next (sh_hi),
      .lower_next (sh_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
         fl_q <= 1'b0;
      end else begin
         unique case (op)
            OP_LOAD: begin
               hi_q <= ld_hi;
               lo_q <= ld_lo;
               fl_q <= ld_flag;
            end
            OP_SIGN: begin
               hi_q <= sh_hi;
               lo_q <= sh_lo;
               fl_q <= sign_flag;
            end
            OP_COND: begin
               hi_q <= sh_hi;
               lo_q <= sh_lo;
               fl_q <= as_flag;
            end
            default: ;
         endcase
      end
   end

   assign quot   = lo_q;
   assign rem_hi = hi_q;
   assign qflag  = fl_q;

endmodule

// File: rtl/divstep_unit_chk.sv
module divstep_unit_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_en,
   input logic [DATA_W-1:0] ld_hi,
   input logic [DATA_W-1:0] ld_lo,
   input logic              ld_flag,
   input logic              step_en,
   input logic              step_sign,
   input logic [DATA_W-1:0] divisor,
   input logic [DATA_W-1:0] quot,
   input logic [DATA_W-1:0] rem_hi,
   input logic              qflag
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] sum_c, dif_c;
   assign sum_c = rem_hi + divisor;
   assign dif_c = rem_hi - divisor;

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (rem_hi == $past(ld_hi)) && (quot == $past(ld_lo)) && (qflag == $past(ld_flag)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !step_en) |=> $stable(rem_hi) && $stable(quot) && $stable(qflag));

   p_sign_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && step_en && step_sign) |=> qflag == ($past(divisor[MSB]) ^ $past(rem_hi[MSB])));

   p_sign_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && step_en && step_sign) |=>
         (quot == {$past(quot[MSB-1:0]), qflag}) &&
         (rem_hi == {$past(rem_hi[MSB-1:0]), $past(quot[MSB])}));

   p_cond_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && step_en && !step_sign) |=>
         rem_hi[MSB:1] == ($past(qflag) ? $past(sum_c[MSB-1:0]) : $past(dif_c[MSB-1:0])));

   p_cond_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && step_en && !step_sign) |=>
         (quot == {$past(quot[MSB-1:0]), ~qflag}) && (rem_hi[0] == $past(quot[MSB])));

endmodule

bind divstep_unit divstep_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/divstep_unit_test.sv
`timescale 1ns/1ps
module divstep_unit_test;

   localparam int W   = 8;
   localparam int MSB = W - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_en = 1'b0;
   logic [W-1:0] ld_hi = '0;
   logic [W-1:0] ld_lo = '0;
   logic         ld_flag = 1'b0;
   logic         step_en = 1'b0;
   logic         step_sign = 1'b0;
   logic [W-1:0] divisor = '0;
   logic [W-1:0] quot, rem_hi;
   logic         qflag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   divstep_unit #(.DATA_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_hi(ld_hi), .ld_lo(ld_lo),
      .ld_flag(ld_flag), .step_en(step_en), .step_sign(step_sign),
      .divisor(divisor), .quot(quot), .rem_hi(rem_hi), .qflag(qflag)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Apply one cycle of inputs; return at the next negedge, after the edge.
   task automatic cyc(input bit ld, input bit st, input bit sg);
      ld_en = ld; step_en = st; step_sign = sg;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0; step_en = 1'b0; step_sign = 1'b0;
   endtask

   task automatic load(input int hi, input int lo, input bit fl);
      ld_hi = hi[W-1:0]; ld_lo = lo[W-1:0]; ld_flag = fl;
      cyc(1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n, q;
      @(negedge clk); @(negedge clk);
      // R1: reset state
      check("R1 hi", rem_hi, 0); check("R1 lo", quot, 0); check("R1 flag", qflag, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: load
      load(8'hA5, 8'h3C, 1'b1);
      check("R2 hi", rem_hi, 8'hA5); check("R2 lo", quot, 8'h3C); check("R2 flag", qflag, 1);
      // R2: load wins over a step in the same cycle
      ld_hi = 8'h12; ld_lo = 8'h34; ld_flag = 1'b0; divisor = 8'h40;
      cyc(1'b1, 1'b1, 1'b0);
      check("R2 prio hi", rem_hi, 8'h12); check("R2 prio lo", quot, 8'h34); check("R2 prio flag", qflag, 0);

      // R3: idle cycles hold
      cyc(1'b0, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0);
      check("R3 hi", rem_hi, 8'h12); check("R3 lo", quot, 8'h34); check("R3 flag", qflag, 0);

      // R4: sign step, each sign combination
      for (int c = 0; c < 4; c++) begin
         int h, l, f;
         h = (c[0] ? 8'h80 : 8'h00) | 8'h29;
         l = (c & 1) ? 8'h96 : 8'h5A;
         divisor = (c[1] ? 8'h80 : 8'h00) | 8'h11;
         load(h, l, 1'b0);
         cyc(1'b0, 1'b1, 1'b1);
         f = c[0] ^ c[1];
         check("R4 flag", qflag, f);
         check("R4 hi", rem_hi, ((h << 1) | (l >> 7)) & 8'hFF);
         check("R4 lo", quot, ((l << 1) | f) & 8'hFF);
      end

      // R5/R6: add with wrap (carry dropped)
      divisor = 8'h20; load(8'hF0, 8'h81, 1'b1);
      cyc(1'b0, 1'b1, 1'b0);
      // result 0x10: flag = 0^0 = 0, lsb = 1
      check("R5 add wrap hi", rem_hi, 8'h21); check("R6 add flag", qflag, 0);
      check("R6 add lo", quot, 8'h03);
      // R5/R6: subtract with borrow
      divisor = 8'h10; load(8'h05, 8'h40, 1'b0);
      cyc(1'b0, 1'b1, 1'b0);
      // result 0xF5: flag = 0^1 = 1, lsb = 0
      check("R5 sub borrow hi", rem_hi, 8'hEA); check("R6 sub flag", qflag, 1);
      check("R6 sub lo", quot, 8'h80);

      // R7 and R8: full divisions, every positive divisor
      for (int d = 1; d < 128; d++) begin
         for (int hi_i = 0; hi_i < 4; hi_i++) begin
            int h;
            h = (hi_i == 0) ? 0 : (hi_i == 1) ? d - 1 : (hi_i == 2) ? d / 2 : d / 3;
            for (int li = 0; li < 4; li++) begin
               int l;
               l = (li == 0) ? 0 : (li == 1) ? 8'hFF : (li == 2) ? 8'h5A : (d * 37) & 8'hFF;
               n = h * 256 + l;
               q = n / (2 * d);
               divisor = d[W-1:0];
               // R7: unsigned
               load(h, l, 1'b0);
               for (int s = 0; s < W; s++) cyc(1'b0, 1'b1, 1'b0);
               check("R7 unsigned quotient", quot, q);
               // R8: signed, positive operands
               load(h, l, 1'b1);
               cyc(1'b0, 1'b1, 1'b1);
               for (int s = 0; s < W - 1; s++) cyc(1'b0, 1'b1, 1'b0);
               check("R8 signed quotient", quot, q);
            end
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule